// File: doc/BRIEF.md
# Command-Mapped Flash Access Decoder

This block sits between a memory-mapped bus window and a flash controller. Every 32-bit word access that lands in the window carries its operation class in two address bits, the map-type field. A data-move access streams page words one per access. A command access writes an operation opcode in its data. A buffer or register access goes straight through to a device word. The rest of the address supplies either a block and page pair or a direct word address, depending on the class.

Software moves a page by repeating data-move accesses at the same block and page address. An internal word position walks through the main area. When the spare-transfer input is high, the position continues into the spare area before it wraps. Erase, unlock-all and erase-verify are single command writes. A lock, unlock or lock-tight range is two command writes: a start opcode at the first block, then the matching end opcode at the last block. A sticky status bit reports a read of a write-protected block. A second sticky bit reports a rejected access. Each bit is cleared by a write-one acknowledge.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is low and right after it, every strobe (fl_rd, fl_wr, dir_rd, dir_wr, cmd_valid, acc_rvalid) and both status bits are 0.
- R2: The map type is acc_addr[MAP_SHIFT+1:MAP_SHIFT] (bits 25:24 by default). 0 is the buffer path, 1 is data move, 2 is command and 3 is register. An accepted access raises exactly one matching strobe in the cycle after it is sampled, and only for that cycle.
- R3: For a data move, fl_block is acc_addr[MAP_SHIFT-1:BLK_SHIFT] (23:12) and fl_page is acc_addr[BLK_SHIFT-1:PAGE_SHIFT] (11:6). Write data appears on out_wdata.
- R4: A map-0 access gives dir_buf=1 and dir_word=acc_addr[MAP_SHIFT-1:1]. A map-3 access gives dir_buf=0 and dir_word=acc_addr[MAP_SHIFT-1:2], zero-extended.
- R5: With spare_mode low, successive data moves to one block and page give fl_spare=0 and fl_word 0 up to PAGE_BYTES/4-1 (511), then 0 again.
- R6: With spare_mode high when the last main word is moved, the following SPARE_BYTES/4 (16) moves give fl_spare=1 and fl_word 0 to 15. The move after those returns to main word 0.
- R7: A data move to a block or page that differs from the previous data move starts again at main word 0.
- R8: A read raises acc_rvalid one cycle later. While acc_rvalid is high, acc_rdata equals fl_rdata for a data move and dir_rdata for maps 0 and 3.
- R9: The command opcode is acc_wdata[7:0]. 0x03 issues kind 0 (erase), 0x0E issues kind 4 (unlock-all) and 0x15 issues kind 5 (erase verify). Each raises cmd_valid for one cycle with cmd_first = cmd_last = the address block.
- R10: A start opcode (0x08 unlock, 0x0A lock, 0x0C lock-tight) raises no strobe. A directly following matching end opcode (0x09, 0x0B, 0x0D) issues kind 1, 2 or 3, with cmd_first taken from the start write's block and cmd_last from the end write's block. Any other command write discards the pending start.
- R11: These accesses raise no strobe and set sts_illegal: an unknown opcode, an end opcode with no matching pending start, a read with map type 2, acc_addr[0]=1, or any nonzero address bit above the map field. An illegal data move does not advance the word position.
- R12: A data-move read whose fl_locked input is high sets sts_locked one cycle after fl_rd. The bit stays set until it is acknowledged. Reads of unlocked blocks leave it clear.
- R13: ack_valid with ack_bits[0]=1 clears sts_locked, and with ack_bits[1]=1 clears sts_illegal. The other bit is unaffected. A new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus word access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 32 | Window byte address with map field |
| acc_wdata | input | 32 | Write data, opcode in [7:0] for commands |
| spare_mode | input | 1 | Continue page moves into the spare area |
| acc_rvalid | output | 1 | Read data valid |
| acc_rdata | output | 32 | Read data |
| fl_rd | output | 1 | Page word read strobe |
| fl_wr | output | 1 | Page word write strobe |
| fl_spare | output | 1 | Word belongs to the spare area |
| fl_block | output | 12 | Block number |
| fl_page | output | 6 | Page within block |
| fl_word | output | 9 | Word index within the area |
| fl_rdata | input | 32 | Page word read data |
| fl_locked | input | 1 | Addressed block is write-protected |
| dir_rd | output | 1 | Direct buffer/register read strobe |
| dir_wr | output | 1 | Direct buffer/register write strobe |
| dir_buf | output | 1 | 1 buffer path, 0 register path |
| dir_word | output | 23 | Direct word address |
| dir_rdata | input | 32 | Direct read data |
| out_wdata | output | 32 | Write data towards the controller |
| cmd_valid | output | 1 | Command issue strobe |
| cmd_kind | output | 3 | Command kind code |
| cmd_first | output | 12 | First block of the command |
| cmd_last | output | 12 | Last block of the command |
| ack_valid | input | 1 | Status acknowledge write |
| ack_bits | input | 2 | Write-one-to-clear mask [0] locked, [1] illegal |
| sts_locked | output | 1 | Sticky protected-block read status |
| sts_illegal | output | 1 | Sticky rejected-access status |

## Verification
The bench walks a full page past its last main word in both spare settings. A counter that is off by one at a boundary, or that ignores the spare flag, shows up as a wrong fl_word or fl_spare at the 512th or 528th move. It switches pages partway through a page, because a decoder without the restart would go on from a stale position. Range commands are sent with matching and mismatched end opcodes, a lone end, and a start that is never closed. A missing pending check would then issue a range with a stale first block, or raise a strobe where none belongs. Acknowledges are sent in the same cycle as a new set, and with the other status bit's mask, to catch a clear that wins over the set or a clear that hits both bits.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    MT_BUF  = 2'd0,
    MT_DATA = 2'd1,
    MT_CMD  = 2'd2,
    MT_REG  = 2'd3
  } map_e;

  typedef enum logic [2:0] {
    CK_ERASE        = 3'd0,
    CK_UNLOCK       = 3'd1,
    CK_LOCK         = 3'd2,
    CK_LOCKTIGHT    = 3'd3,
    CK_UNLOCK_ALL   = 3'd4,
    CK_ERASE_VERIFY = 3'd5
  } cmd_kind_e;

  localparam logic [7:0] OP_ERASE     = 8'h03;
  localparam logic [7:0] OP_UNL_BEGIN = 8'h08;
  localparam logic [7:0] OP_UNL_END   = 8'h09;
  localparam logic [7:0] OP_LCK_BEGIN = 8'h0A;
  localparam logic [7:0] OP_LCK_END   = 8'h0B;
  localparam logic [7:0] OP_LT_BEGIN  = 8'h0C;
  localparam logic [7:0] OP_LT_END    = 8'h0D;
  localparam logic [7:0] OP_UNL_ALL   = 8'h0E;
  localparam logic [7:0] OP_ERS_VFY   = 8'h15;

endpackage

// File: rtl/fcd_addr_split.sv
module fcd_addr_split
  import fcd_pkg::*;
#(
  parameter int MAP_SHIFT  = 24,
  parameter int BLK_SHIFT  = 12,
  parameter int PAGE_SHIFT = 6,
  localparam int BLK_W = MAP_SHIFT - BLK_SHIFT,
  localparam int PG_W  = BLK_SHIFT - PAGE_SHIFT,
  localparam int DW_W  = MAP_SHIFT - 1
) (
  input  logic [31:0]      addr,
  output map_e             map_type,
  output logic [BLK_W-1:0] blk,
  output logic [PG_W-1:0]  pg,
  output logic [DW_W-1:0]  buf_word,
  output logic [DW_W-1:0]  reg_word,
  output logic             addr_bad
);

  assign map_type = map_e'(addr[MAP_SHIFT+1:MAP_SHIFT]);
  assign blk      = addr[MAP_SHIFT-1:BLK_SHIFT];
  assign pg       = addr[BLK_SHIFT-1:PAGE_SHIFT];
  assign buf_word = addr[MAP_SHIFT-1:1];
  assign reg_word = {1'b0, addr[MAP_SHIFT-1:2]};
  // misaligned word or stray bits above the map field
  assign addr_bad = addr[0] | (|addr[31:MAP_SHIFT+2]);

endmodule

// File: rtl/fcd_word_ctr.sv
module fcd_word_ctr #(
  parameter int BLK_W       = 12,
  parameter int PG_W        = 6,
  parameter int MAIN_WORDS  = 512,
  parameter int SPARE_WORDS = 16,
  parameter int IDX_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             spare_mode,
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  pg,
  output logic             cur_spare,
  output logic [IDX_W-1:0] cur_idx
);

  localparam logic [IDX_W-1:0] MAIN_LAST = IDX_W'(MAIN_WORDS - 1);
  localparam logic [IDX_W-1:0] SP_LAST   = IDX_W'(SPARE_WORDS - 1);

  logic             tag_ok_q;
  logic [BLK_W-1:0] tag_blk_q;
  logic [PG_W-1:0]  tag_pg_q;
  logic             sp_q, sp_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             hit;

  // position for the access in flight; a new page starts at main word 0
  always_comb begin
    hit       = tag_ok_q && (blk == tag_blk_q) && (pg == tag_pg_q);
    cur_spare = hit ? sp_q  : 1'b0;
    cur_idx   = hit ? idx_q : '0;
    sp_n      = cur_spare;
    idx_n     = cur_idx + 1'b1;
    if (cur_spare) begin
      if (cur_idx == SP_LAST) begin
        sp_n  = 1'b0;
        idx_n = '0;
      end
    end else if (cur_idx == MAIN_LAST) begin
      sp_n  = spare_mode;
      idx_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_ok_q  <= 1'b0;
      tag_blk_q <= '0;
      tag_pg_q  <= '0;
      sp_q      <= 1'b0;
      idx_q     <= '0;
    end else if (step) begin
      tag_ok_q  <= 1'b1;
      tag_blk_q <= blk;
      tag_pg_q  <= pg;
      sp_q      <= sp_n;
      idx_q     <= idx_n;
    end
  end

  // R6
  spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q |-> (idx_q <= SP_LAST));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx_q) && $stable(sp_q));

endmodule

// File: rtl/fcd_cmd_seq.sv
module fcd_cmd_seq
  import fcd_pkg::*;
#(
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       op,
  input  logic [BLK_W-1:0] blk,
  output logic             emit,
  output cmd_kind_e        kind,
  output logic [BLK_W-1:0] first,
  output logic [BLK_W-1:0] last,
  output logic             bad
);

  logic             pend_q, pend_n;
  cmd_kind_e        pkind_q, pkind_n;
  logic [BLK_W-1:0] pfirst_q, pfirst_n;
  logic             is_end;
  cmd_kind_e        end_kind;

  always_comb begin
    emit     = 1'b0;
    kind     = CK_ERASE;
    first    = blk;
    last     = blk;
    bad      = 1'b0;
    is_end   = 1'b0;
    end_kind = CK_UNLOCK;
    pend_n   = pend_q;
    pkind_n  = pkind_q;
    pfirst_n = pfirst_q;
    if (wr) begin
      pend_n = 1'b0;
      case (op)
        OP_ERASE:     begin emit = 1'b1; kind = CK_ERASE;        end
        OP_UNL_ALL:   begin emit = 1'b1; kind = CK_UNLOCK_ALL;   end
        OP_ERS_VFY:   begin emit = 1'b1; kind = CK_ERASE_VERIFY; end
        OP_UNL_BEGIN: begin pend_n = 1'b1; pkind_n = CK_UNLOCK;    pfirst_n = blk; end
        OP_LCK_BEGIN: begin pend_n = 1'b1; pkind_n = CK_LOCK;      pfirst_n = blk; end
        OP_LT_BEGIN:  begin pend_n = 1'b1; pkind_n = CK_LOCKTIGHT; pfirst_n = blk; end
        OP_UNL_END:   begin is_end = 1'b1; end_kind = CK_UNLOCK;    end
        OP_LCK_END:   begin is_end = 1'b1; end_kind = CK_LOCK;      end
        OP_LT_END:    begin is_end = 1'b1; end_kind = CK_LOCKTIGHT; end
        default:      bad = 1'b1;
      endcase
      if (is_end) begin
        if (pend_q && (pkind_q == end_kind)) begin
          emit  = 1'b1;
          kind  = end_kind;
          first = pfirst_q;
        end else begin
          bad = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pkind_q  <= CK_UNLOCK;
      pfirst_q <= '0;
    end else if (wr) begin
      pend_q   <= pend_n;
      pkind_q  <= pkind_n;
      pfirst_q <= pfirst_n;
    end
  end

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr) |=> pend_q && $stable(pfirst_q) && $stable(pkind_q));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int MAP_SHIFT   = 24,
  parameter int BLK_SHIFT   = 12,
  parameter int PAGE_SHIFT  = 6,
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  localparam int MAIN_WORDS  = PAGE_BYTES / 4,
  localparam int SPARE_WORDS = SPARE_BYTES / 4,
  localparam int BLK_W = MAP_SHIFT - BLK_SHIFT,
  localparam int PG_W  = BLK_SHIFT - PAGE_SHIFT,
  localparam int IDX_W = $clog2((MAIN_WORDS > SPARE_WORDS) ? MAIN_WORDS : SPARE_WORDS),
  localparam int DW_W  = MAP_SHIFT - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [31:0]      acc_addr,
  input  logic [31:0]      acc_wdata,
  input  logic             spare_mode,
  output logic             acc_rvalid,
  output logic [31:0]      acc_rdata,
  output logic             fl_rd,
  output logic             fl_wr,
  output logic             fl_spare,
  output logic [BLK_W-1:0] fl_block,
  output logic [PG_W-1:0]  fl_page,
  output logic [IDX_W-1:0] fl_word,
  input  logic [31:0]      fl_rdata,
  input  logic             fl_locked,
  output logic             dir_rd,
  output logic             dir_wr,
  output logic             dir_buf,
  output logic [DW_W-1:0]  dir_word,
  input  logic [31:0]      dir_rdata,
  output logic [31:0]      out_wdata,
  output logic             cmd_valid,
  output logic [2:0]       cmd_kind,
  output logic [BLK_W-1:0] cmd_first,
  output logic [BLK_W-1:0] cmd_last,
  input  logic             ack_valid,
  input  logic [1:0]       ack_bits,
  output logic             sts_locked,
  output logic             sts_illegal
);

  map_e             map_c;
  logic [BLK_W-1:0] blk_c;
  logic [PG_W-1:0]  pg_c;
  logic [DW_W-1:0]  bufw_c, regw_c;
  logic             addr_bad_c;

  fcd_addr_split #(
    .MAP_SHIFT(MAP_SHIFT), .BLK_SHIFT(BLK_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_split (
    .addr(acc_addr), .map_type(map_c), .blk(blk_c), .pg(pg_c),
    .buf_word(bufw_c), .reg_word(regw_c), .addr_bad(addr_bad_c)
  );

  logic             step_c, cur_sp_c;
  logic [IDX_W-1:0] cur_idx_c;

  fcd_word_ctr #(
    .BLK_W(BLK_W), .PG_W(PG_W), .MAIN_WORDS(MAIN_WORDS),
    .SPARE_WORDS(SPARE_WORDS), .IDX_W(IDX_W)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(step_c), .spare_mode(spare_mode),
    .blk(blk_c), .pg(pg_c), .cur_spare(cur_sp_c), .cur_idx(cur_idx_c)
  );

  logic             cmd_wr_c, emit_c, seq_bad_c;
  cmd_kind_e        kind_c;
  logic [BLK_W-1:0] first_c, last_c;

  fcd_cmd_seq #(.BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr_c), .op(acc_wdata[7:0]), .blk(blk_c),
    .emit(emit_c), .kind(kind_c), .first(first_c), .last(last_c), .bad(seq_bad_c)
  );

  // next-state signals
  logic fl_rd_n, fl_wr_n, dir_rd_n, dir_wr_n, map_bad_c, ill_set_c, lck_set_c;
  logic ld_c, rd_ld_c, sts_locked_n, sts_illegal_n;

  // registered state
  logic             fl_rd_q, fl_wr_q, fl_sp_q, dir_rd_q, dir_wr_q, dir_buf_q;
  logic             rvalid_q, rd_flash_q, cmd_valid_q, sts_locked_q, sts_illegal_q;
  logic [BLK_W-1:0] fl_blk_q, cmd_first_q, cmd_last_q;
  logic [PG_W-1:0]  fl_pg_q;
  logic [IDX_W-1:0] fl_word_q;
  logic [DW_W-1:0]  dir_word_q;
  logic [31:0]      wdata_q;
  logic [2:0]       cmd_kind_q;

  always_comb begin
    fl_rd_n   = 1'b0;
    fl_wr_n   = 1'b0;
    dir_rd_n  = 1'b0;
    dir_wr_n  = 1'b0;
    step_c    = 1'b0;
    cmd_wr_c  = 1'b0;
    map_bad_c = 1'b0;
    if (acc_valid && !addr_bad_c) begin
      case (map_c)
        MT_DATA: begin
          step_c  = 1'b1;
          fl_rd_n = !acc_write;
          fl_wr_n = acc_write;
        end
        MT_CMD: begin
          cmd_wr_c  = acc_write;
          map_bad_c = !acc_write;
        end
        default: begin
          dir_rd_n = !acc_write;
          dir_wr_n = acc_write;
        end
      endcase
    end
    ld_c          = acc_valid;
    rd_ld_c       = acc_valid && !acc_write;
    ill_set_c     = acc_valid && (addr_bad_c || map_bad_c || seq_bad_c);
    lck_set_c     = fl_rd_q && fl_locked;
    sts_locked_n  = lck_set_c || (sts_locked_q && !(ack_valid && ack_bits[0]));
    sts_illegal_n = ill_set_c || (sts_illegal_q && !(ack_valid && ack_bits[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_rd_q       <= 1'b0;
      fl_wr_q       <= 1'b0;
      dir_rd_q      <= 1'b0;
      dir_wr_q      <= 1'b0;
      rvalid_q      <= 1'b0;
      cmd_valid_q   <= 1'b0;
      sts_locked_q  <= 1'b0;
      sts_illegal_q <= 1'b0;
      fl_sp_q       <= 1'b0;
      fl_blk_q      <= '0;
      fl_pg_q       <= '0;
      fl_word_q     <= '0;
      dir_buf_q     <= 1'b0;
      dir_word_q    <= '0;
      wdata_q       <= '0;
      rd_flash_q    <= 1'b0;
      cmd_kind_q    <= '0;
      cmd_first_q   <= '0;
      cmd_last_q    <= '0;
    end else begin
      fl_rd_q       <= fl_rd_n;
      fl_wr_q       <= fl_wr_n;
      dir_rd_q      <= dir_rd_n;
      dir_wr_q      <= dir_wr_n;
      rvalid_q      <= fl_rd_n | dir_rd_n;
      cmd_valid_q   <= emit_c;
      sts_locked_q  <= sts_locked_n;
      sts_illegal_q <= sts_illegal_n;
      if (ld_c) begin
        fl_sp_q    <= cur_sp_c;
        fl_blk_q   <= blk_c;
        fl_pg_q    <= pg_c;
        fl_word_q  <= cur_idx_c;
        dir_buf_q  <= (map_c == MT_BUF);
        dir_word_q <= (map_c == MT_BUF) ? bufw_c : regw_c;
        wdata_q    <= acc_wdata;
      end
      if (rd_ld_c) begin
        rd_flash_q <= (map_c == MT_DATA);
      end
      if (emit_c) begin
        cmd_kind_q  <= kind_c;
        cmd_first_q <= first_c;
        cmd_last_q  <= last_c;
      end
    end
  end

  assign fl_rd       = fl_rd_q;
  assign fl_wr       = fl_wr_q;
  assign fl_spare    = fl_sp_q;
  assign fl_block    = fl_blk_q;
  assign fl_page     = fl_pg_q;
  assign fl_word     = fl_word_q;
  assign dir_rd      = dir_rd_q;
  assign dir_wr      = dir_wr_q;
  assign dir_buf     = dir_buf_q;
  assign dir_word    = dir_word_q;
  assign out_wdata   = wdata_q;
  assign cmd_valid   = cmd_valid_q;
  assign cmd_kind    = cmd_kind_q;
  assign cmd_first   = cmd_first_q;
  assign cmd_last    = cmd_last_q;
  assign acc_rvalid  = rvalid_q;
  assign acc_rdata   = rd_flash_q ? fl_rdata : dir_rdata;
  assign sts_locked  = sts_locked_q;
  assign sts_illegal = sts_illegal_q;

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_rd, fl_wr, dir_rd, dir_wr, cmd_valid}));

  // R11
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd || fl_wr || dir_rd || dir_wr || cmd_valid) |-> $past(acc_valid));

  // R8
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $past(acc_valid && !acc_write));

  // R12
  locked_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_locked) |-> $past(fl_rd && fl_locked));

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, spare_mode, ack_valid;
  logic [31:0] acc_addr, acc_wdata;
  logic [1:0]  ack_bits;
  logic        acc_rvalid, fl_rd, fl_wr, fl_spare, fl_locked;
  logic [31:0] acc_rdata, fl_rdata, dir_rdata, out_wdata;
  logic [11:0] fl_block, cmd_first, cmd_last;
  logic [5:0]  fl_page;
  logic [8:0]  fl_word;
  logic        dir_rd, dir_wr, dir_buf, cmd_valid, sts_locked, sts_illegal;
  logic [22:0] dir_word;
  logic [2:0]  cmd_kind;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [11:0] PROT_BLK = 12'h0A5;

  always #5 clk = ~clk;

  // page store and register file stand-ins
  assign fl_rdata  = {fl_block, fl_page, 4'h0, fl_spare, fl_word};
  assign fl_locked = (fl_block == PROT_BLK);
  assign dir_rdata = {dir_buf, 8'h5A, dir_word};

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .spare_mode(spare_mode),
    .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata), .fl_rd(fl_rd), .fl_wr(fl_wr),
    .fl_spare(fl_spare), .fl_block(fl_block), .fl_page(fl_page), .fl_word(fl_word),
    .fl_rdata(fl_rdata), .fl_locked(fl_locked), .dir_rd(dir_rd), .dir_wr(dir_wr),
    .dir_buf(dir_buf), .dir_word(dir_word), .dir_rdata(dir_rdata),
    .out_wdata(out_wdata), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_first(cmd_first), .cmd_last(cmd_last), .ack_valid(ack_valid),
    .ack_bits(ack_bits), .sts_locked(sts_locked), .sts_illegal(sts_illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] strb();
    return {fl_rd, fl_wr, dir_rd, dir_wr, cmd_valid};
  endfunction

  function automatic logic [31:0] a_mem(input logic [1:0] m, input logic [11:0] b, input logic [5:0] p);
    return {6'b0, m, b, p, 6'b0};
  endfunction

  task automatic acc(input bit w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic ack(input logic [1:0] bits);
    @(negedge clk);
    ack_valid = 1'b1; ack_bits = bits;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  // bench model of the word position
  bit          m_ok = 1'b0;
  logic [11:0] m_b;
  logic [5:0]  m_p;
  bit          m_sp;
  int          m_ix;

  task automatic ctr_exp(input logic [11:0] b, input logic [5:0] p, input bit spm,
                         output bit esp, output int eix);
    if (!(m_ok && m_b == b && m_p == p)) begin m_sp = 1'b0; m_ix = 0; end
    esp = m_sp; eix = m_ix;
    if (m_sp) begin
      if (m_ix == 15) begin m_sp = 1'b0; m_ix = 0; end else m_ix++;
    end else if (m_ix == 511) begin
      m_sp = spm; m_ix = 0;
    end else m_ix++;
    m_ok = 1'b1; m_b = b; m_p = p;
  endtask

  task automatic move(input bit w, input logic [11:0] b, input logic [5:0] p,
                      input logic [31:0] d, input string req);
    bit esp; int eix;
    ctr_exp(b, p, spare_mode, esp, eix);
    acc(w, a_mem(2'd1, b, p), d);
    chk(req, strb(), {!w, w, 3'b000});
    chk(req, {fl_block, fl_page}, {b, p});
    chk(req, {fl_spare, fl_word}, {esp, 9'(eix)});
    if (w) chk(req, out_wdata, d);
    else   chk(req, acc_rdata, {b, p, 4'h0, esp, 9'(eix)});
  endtask

  task automatic cmd(input logic [11:0] b, input logic [7:0] op);
    acc(1'b1, a_mem(2'd2, b, 6'd0), {24'hABCDEF, op});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    spare_mode = 1'b0; ack_valid = 1'b0; ack_bits = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", {strb(), acc_rvalid, sts_locked, sts_illegal}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {strb(), acc_rvalid, sts_locked, sts_illegal}, '0);

    // R2 R3 R8 data move read
    move(1'b0, 12'h005, 6'd3, 32'h0, "R3");
    chk("R8", acc_rvalid, 1'b1);
    // R3 data move write
    move(1'b1, 12'h005, 6'd3, 32'hC0FFEE01, "R3");
    chk("R8", acc_rvalid, 1'b0);

    // R4 buffer path write and register path read
    acc(1'b1, {6'b0, 2'd0, 23'h12345, 1'b0}, 32'h0BADF00D);
    chk("R4", strb(), 5'b00010);
    chk("R4", {dir_buf, dir_word, out_wdata}, {1'b1, 23'h12345, 32'h0BADF00D});
    acc(1'b0, {6'b0, 2'd3, 22'h2ABCD, 2'b00}, 32'h0);
    chk("R4", strb(), 5'b00100);
    chk("R4", {dir_buf, dir_word}, {1'b0, 1'b0, 22'h2ABCD});
    chk("R8", {acc_rvalid, acc_rdata}, {1'b1, 1'b0, 8'h5A, 1'b0, 22'h2ABCD});

    // R5 full page, main only, and wrap
    spare_mode = 1'b0;
    for (int i = 0; i < 514; i++) move(1'b0, 12'h007, 6'd1, 32'h0, "R5");

    // R6 spare continuation on writes
    spare_mode = 1'b1;
    for (int i = 0; i < 531; i++) move(1'b1, 12'h008, 6'd2, 32'h1000 + i, "R6");

    // R7 page switch restarts
    for (int i = 0; i < 5; i++) move(1'b0, 12'h009, 6'd4, 32'h0, "R7");
    move(1'b0, 12'h009, 6'd5, 32'h0, "R7");
    chk("R7", fl_word, 9'd0);
    move(1'b0, 12'h009, 6'd4, 32'h0, "R7");
    chk("R7", fl_word, 9'd0);

    // R9 single commands
    cmd(12'h033, 8'h03);
    chk("R9", {strb(), cmd_kind, cmd_first, cmd_last}, {5'b00001, 3'd0, 12'h033, 12'h033});
    cmd(12'h044, 8'h0E);
    chk("R9", {strb(), cmd_kind, cmd_first, cmd_last}, {5'b00001, 3'd4, 12'h044, 12'h044});
    cmd(12'h055, 8'h15);
    chk("R9", {strb(), cmd_kind, cmd_first, cmd_last}, {5'b00001, 3'd5, 12'h055, 12'h055});

    // R10 ranges
    cmd(12'h004, 8'h0A);
    chk("R10", strb(), 5'b0);
    cmd(12'h009, 8'h0B);
    chk("R10", {strb(), cmd_kind, cmd_first, cmd_last}, {5'b00001, 3'd2, 12'h004, 12'h009});
    cmd(12'h010, 8'h08);
    acc(1'b0, a_mem(2'd0, 12'h001, 6'd0), 32'h0);
    cmd(12'h01F, 8'h09);
    chk("R10", {strb(), cmd_kind, cmd_first, cmd_last}, {5'b00001, 3'd1, 12'h010, 12'h01F});
    cmd(12'h020, 8'h0C);
    cmd(12'h022, 8'h0D);
    chk("R10", {strb(), cmd_kind, cmd_first, cmd_last}, {5'b00001, 3'd3, 12'h020, 12'h022});
    chk("R11", sts_illegal, 1'b0);

    // R11 rejected accesses
    cmd(12'h001, 8'h0B);
    chk("R11", {strb(), sts_illegal}, {5'b0, 1'b1});
    ack(2'b10);
    chk("R13", sts_illegal, 1'b0);
    cmd(12'h001, 8'h0A);
    cmd(12'h002, 8'h09);
    chk("R11", {strb(), sts_illegal}, {5'b0, 1'b1});
    ack(2'b10);
    cmd(12'h001, 8'h0C);
    cmd(12'h001, 8'h03);
    cmd(12'h003, 8'h0D);
    chk("R11", {strb(), sts_illegal}, {5'b0, 1'b1});
    ack(2'b10);
    cmd(12'h001, 8'h77);
    chk("R11", {strb(), sts_illegal}, {5'b0, 1'b1});
    ack(2'b10);
    acc(1'b0, a_mem(2'd2, 12'h001, 6'd0), 32'h0);
    chk("R11", {strb(), acc_rvalid, sts_illegal}, {5'b0, 1'b0, 1'b1});
    ack(2'b10);
    acc(1'b0, {6'b0, 2'd0, 23'h00001, 1'b1}, 32'h0);
    chk("R11", {strb(), sts_illegal}, {5'b0, 1'b1});
    ack(2'b10);
    acc(1'b1, a_mem(2'd1, 12'h002, 6'd0) | 32'h1000_0000, 32'h0);
    chk("R11", {strb(), sts_illegal}, {5'b0, 1'b1});
    ack(2'b10);
    chk("R13", sts_illegal, 1'b0);

    // R12 locked block
    chk("R12", sts_locked, 1'b0);
    move(1'b0, PROT_BLK, 6'd0, 32'h0, "R12");
    chk("R12", sts_locked, 1'b0);
    @(negedge clk);
    chk("R12", sts_locked, 1'b1);
    move(1'b0, 12'h006, 6'd0, 32'h0, "R12");
    chk("R12", sts_locked, 1'b1);
    // R13 wrong bit leaves it, right bit clears
    ack(2'b10);
    chk("R13", sts_locked, 1'b1);
    ack(2'b01);
    chk("R13", sts_locked, 1'b0);
    // R13 set wins over simultaneous clear
    move(1'b0, PROT_BLK, 6'd0, 32'h0, "R13");
    ack_valid = 1'b1; ack_bits = 2'b01;
    @(negedge clk);
    ack_valid = 1'b0;
    chk("R13", sts_locked, 1'b1);
    ack(2'b01);
    chk("R13", sts_locked, 1'b0);

    // random mix over the data, buffer and register paths (R2 R3 R4 R5 R8)
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom;
      bit w = r[4];
      spare_mode = r[5];
      case (r % 3)
        0: move(w, 12'(1 + (r >> 8) % 3), 6'((r >> 12) % 2), $urandom, "R2");
        1: begin
          logic [22:0] wd = 23'($urandom);
          acc(w, {6'b0, 2'd0, wd, 1'b0}, 32'h5555AAAA);
          chk("R4", {strb(), dir_buf, dir_word}, {1'b0, 1'b0, !w, w, 1'b0, 1'b1, wd});
          if (!w) chk("R8", acc_rdata, {1'b1, 8'h5A, wd});
        end
        default: begin
          logic [21:0] wr = 22'($urandom);
          acc(w, {6'b0, 2'd3, wr, 2'b00}, 32'h3C3C3C3C);
          chk("R4", {strb(), dir_buf, dir_word}, {1'b0, 1'b0, !w, w, 1'b0, 1'b0, 1'b0, wr});
          if (!w) chk("R8", acc_rdata, {1'b0, 8'h5A, 1'b0, wr});
        end
      endcase
    end
    chk("R11", {sts_illegal, sts_locked}, 2'b00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule